// File: doc/BRIEF.md
# Reset Pin Stretch and Retest Controller

This block owns an open-drain, active-low reset pad that is shared between the chip and the board. A reset can come from three places: the pad pulled low by the board, a request from logic inside the chip, or power-on. For any of these the block pulls the pad low for a fixed stretch so that every device on the board gets a reset of known length. It then lets go of the pad for a short window and reads it back. When the pad reads high, the block issues a one-cycle pulse that starts reset exception processing. When the pad still reads low, another device is holding it, so the block pulls it low again and repeats the loop.

An external reset is only accepted after the synchronised pad level has stayed low for a minimum number of consecutive cycles. Once accepted, the block does not act on it while a bus cycle is in progress, so that a write is not cut short. It acts when the bus goes idle or when the bus monitor signals a timeout. At power-on the internal master reset is left released, and the pad is held low until the PLL reports lock and one further stretch period has passed. While any reset is in progress, a safe-state output tells the other pin controllers to drive their pins inactive.

Top module: `rstpin_ctrl`

## Requirements
- R1: While `por_n` is low, `pin_drive` and `pins_safe` are 1 and `sys_rst` and `rst_done` are 0.
- R2: After `por_n` rises, `pin_drive` stays 1 until `pll_locked` is seen high and then for exactly STRETCH_CYC more cycles. `sys_rst` stays 0 for the whole power-on sequence.
- R3: Every drive period is followed by RELEASE_CYC cycles with `pin_drive` at 0. If the pad reads high at the end of that window, `rst_done` is 1 for exactly one cycle and the block then returns to idle.
- R4: If the pad reads low at the end of a release window, the block drives it for another STRETCH_CYC cycles and then opens a new release window. This repeats until the pad reads high.
- R5: `int_req` seen high while idle makes `pin_drive` and `sys_rst` 1 in the next cycle. The pad is driven for STRETCH_CYC cycles, or for as long as `int_req` stays high if that is longer.
- R6: An external reset is accepted only after MIN_LOW consecutive low samples of the synchronised pad. A shorter low pulse leaves `pin_drive`, `sys_rst` and `pins_safe` at 0.
- R7: While an accepted external reset is still held low by the board, `sys_rst` is 1 and `pin_drive` is 0. Once the pad is seen high, the block drives it for exactly STRETCH_CYC cycles.
- R8: An accepted external reset has no effect on `sys_rst` or `pins_safe` while `bus_busy` is 1. It takes effect in the cycle after `bus_busy` is seen low or `bus_tmo` is seen high.
- R9: `pins_safe` is 1 whenever `sys_rst` or `pin_drive` is 1, and it is 0 while the block is idle.
- R10: Outside the power-on sequence, `sys_rst` falls in the same cycle in which `rst_done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| pin_in | input | 1 | Level read back from the reset pad (low = reset) |
| int_req | input | 1 | Reset request from logic inside the chip |
| pll_locked | input | 1 | PLL lock flag |
| bus_busy | input | 1 | A bus cycle is in progress |
| bus_tmo | input | 1 | Bus monitor timeout pulse |
| pin_drive | output | 1 | 1 = pull the pad low |
| sys_rst | output | 1 | Internal master reset |
| pins_safe | output | 1 | Force the other controlled pins to their inactive state |
| rst_done | output | 1 | One-cycle pulse that starts reset exception processing |

## Verification
The bench builds the block with STRETCH_CYC=16, RELEASE_CYC=6 and MIN_LOW=4. With these values every stretch, release window and retest repetition can be counted cycle by cycle in a short run. A glitch one sample shorter than the filter, a request that outlasts the stretch by 20 cycles, and two drive-release-test rounds all fit in a few hundred cycles. The bench models the pad as a wired-AND of the block's drive and a board-side pull-down, so that release and retest are seen at the pin exactly as the board would see them.

// File: rtl/rstpin_pkg.sv
package rstpin_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WAIT_BUS,
        S_DRIVE,
        S_EXTEND,
        S_RELEASE,
        S_TEST,
        S_DONE
    } rp_state_e;

    typedef enum logic [1:0] {
        SRC_EXT,
        SRC_INT,
        SRC_POR
    } rp_src_e;

endpackage

// File: rtl/rstpin_sync.sv
module rstpin_sync (
    input  logic clk,
    input  logic por_n,
    input  logic async_in,
    output logic sync_out
);
    logic meta_q, meta_d;
    logic stab_q, stab_d;

    always_comb begin
        meta_d = async_in;
        stab_d = meta_q;
    end

    // Both stages reset to the released (high) pad level.
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            meta_q <= 1'b1;
            stab_q <= 1'b1;
        end else begin
            meta_q <= meta_d;
            stab_q <= stab_d;
        end
    end

    assign sync_out = stab_q;
endmodule

// File: rtl/rstpin_lowfilt.sv
module rstpin_lowfilt #(
    parameter int MIN_LOW = 8
) (
    input  logic clk,
    input  logic por_n,
    input  logic en,
    input  logic low_in,
    output logic hit
);
    localparam int FW = (MIN_LOW > 1) ? $clog2(MIN_LOW + 1) : 1;
    localparam logic [FW-1:0] LAST = FW'(MIN_LOW - 1);

    logic [FW-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (!en || !low_in) begin
            cnt_d = '0;
        end else if (cnt_q != LAST) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit = en && low_in && (cnt_q == LAST);

    generate
        if (MIN_LOW > 1) begin : g_chk
            // R6: acceptance needs the low level in the previous sample as well
            a_r6_filter_run: assert property (@(posedge clk) disable iff (!por_n)
                hit |-> $past(low_in));
        end
    endgenerate
endmodule

// File: rtl/rstpin_ctrl.sv
module rstpin_ctrl
    import rstpin_pkg::*;
#(
    parameter int STRETCH_CYC = 512,
    parameter int RELEASE_CYC = 10,
    parameter int MIN_LOW     = 8
) (
    input  logic clk,
    input  logic por_n,
    input  logic pin_in,
    input  logic int_req,
    input  logic pll_locked,
    input  logic bus_busy,
    input  logic bus_tmo,
    output logic pin_drive,
    output logic sys_rst,
    output logic pins_safe,
    output logic rst_done
);
    localparam int CNT_MAX = (STRETCH_CYC > RELEASE_CYC) ? STRETCH_CYC : RELEASE_CYC;
    localparam int CW      = $clog2(CNT_MAX + 1);
    localparam logic [CW-1:0] DRV_LAST = CW'(STRETCH_CYC - 1);
    localparam logic [CW-1:0] REL_LAST = CW'(RELEASE_CYC - 2);

    typedef struct packed {
        rp_state_e     st;
        rp_src_e       src;
        logic [CW-1:0] cnt;
        logic          por;
    } fsm_t;

    fsm_t cur_q, nxt_d;
    logic pin_s;
    logic ext_hit;
    logic active;

    rstpin_sync u_sync (
        .clk      (clk),
        .por_n    (por_n),
        .async_in (pin_in),
        .sync_out (pin_s)
    );

    rstpin_lowfilt #(.MIN_LOW(MIN_LOW)) u_filt (
        .clk    (clk),
        .por_n  (por_n),
        .en     (cur_q.st == S_IDLE),
        .low_in (!pin_s),
        .hit    (ext_hit)
    );

    always_comb begin
        nxt_d = cur_q;
        case (cur_q.st)
            S_IDLE: begin
                nxt_d.cnt = '0;
                if (int_req) begin
                    nxt_d.st  = S_DRIVE;
                    nxt_d.src = SRC_INT;
                end else if (ext_hit) begin
                    nxt_d.st  = S_WAIT_BUS;
                    nxt_d.src = SRC_EXT;
                end
            end
            S_WAIT_BUS: begin
                if (int_req) begin
                    nxt_d.st  = S_DRIVE;
                    nxt_d.src = SRC_INT;
                    nxt_d.cnt = '0;
                end else if (!bus_busy || bus_tmo) begin
                    nxt_d.st  = S_EXTEND;
                    nxt_d.src = SRC_EXT;
                end
            end
            S_EXTEND: begin
                nxt_d.cnt = '0;
                case (cur_q.src)
                    SRC_INT: if (!int_req)   nxt_d.st = S_RELEASE;
                    SRC_POR: if (pll_locked) nxt_d.st = S_DRIVE;
                    default: if (pin_s)      nxt_d.st = S_DRIVE;
                endcase
            end
            S_DRIVE: begin
                if (cur_q.cnt == DRV_LAST) begin
                    nxt_d.cnt = '0;
                    if (cur_q.src == SRC_INT && int_req) nxt_d.st = S_EXTEND;
                    else                                 nxt_d.st = S_RELEASE;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            S_RELEASE: begin
                if (cur_q.cnt == REL_LAST) begin
                    nxt_d.st  = S_TEST;
                    nxt_d.cnt = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            S_TEST: begin
                nxt_d.cnt = '0;
                if (pin_s) begin
                    nxt_d.st = S_DONE;
                end else begin
                    nxt_d.st  = S_DRIVE;
                    nxt_d.src = SRC_EXT;
                end
            end
            S_DONE: begin
                nxt_d.st  = S_IDLE;
                nxt_d.por = 1'b0;
            end
            default: nxt_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            cur_q.st  <= S_EXTEND;
            cur_q.src <= SRC_POR;
            cur_q.cnt <= '0;
            cur_q.por <= 1'b1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign active    = (cur_q.st == S_DRIVE) || (cur_q.st == S_EXTEND) ||
                       (cur_q.st == S_RELEASE) || (cur_q.st == S_TEST);
    assign pin_drive = (cur_q.st == S_DRIVE) ||
                       ((cur_q.st == S_EXTEND) && (cur_q.src != SRC_EXT));
    assign sys_rst   = active && !cur_q.por;
    assign pins_safe = active;
    assign rst_done  = (cur_q.st == S_DONE);

    // R3: the done indication never lasts two cycles
    a_r3_done_single: assert property (@(posedge clk) disable iff (!por_n)
        rst_done |=> !rst_done);

    // R10: the master reset only ends together with the done pulse
    a_r10_fall_with_done: assert property (@(posedge clk) disable iff (!por_n)
        $fell(sys_rst) |-> rst_done);

    // R9: any reset activity keeps the other pins safe
    a_r9_safe_cover: assert property (@(posedge clk) disable iff (!por_n)
        (sys_rst || pin_drive) |-> pins_safe);

    // R8: a busy bus holds off an accepted external reset
    a_r8_bus_defer: assert property (@(posedge clk) disable iff (!por_n)
        (cur_q.st == S_WAIT_BUS && bus_busy && !bus_tmo && !int_req) |=> !sys_rst);

    // R5: an internal request while idle drives the pad next cycle
    a_r5_int_drive: assert property (@(posedge clk) disable iff (!por_n)
        (cur_q.st == S_IDLE && int_req) |=> pin_drive);

    // R4: a low pad at the test point leads straight back to driving
    a_r4_retry_drive: assert property (@(posedge clk) disable iff (!por_n)
        (cur_q.st == S_TEST && !pin_s) |=> pin_drive);
endmodule

// File: tb/rstpin_ctrl_bench.sv
module rstpin_ctrl_bench;
    localparam int STR = 16;
    localparam int REL = 6;
    localparam int MNL = 4;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic ext_low = 1'b0;
    logic int_req = 1'b0;
    logic pll_locked = 1'b0;
    logic bus_busy = 1'b0;
    logic bus_tmo = 1'b0;
    logic pin_in;
    logic pin_drive, sys_rst, pins_safe, rst_done;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    // wired-AND pad: low if the block or the board pulls it
    assign pin_in = !(pin_drive || ext_low);

    rstpin_ctrl #(.STRETCH_CYC(STR), .RELEASE_CYC(REL), .MIN_LOW(MNL)) u_rstpin_ctrl (
        .clk(clk), .por_n(por_n), .pin_in(pin_in), .int_req(int_req),
        .pll_locked(pll_locked), .bus_busy(bus_busy), .bus_tmo(bus_tmo),
        .pin_drive(pin_drive), .sys_rst(sys_rst), .pins_safe(pins_safe),
        .rst_done(rst_done)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // count negedges with pin_drive high, starting at the current negedge
    task automatic run_high(output int n);
        while (!pin_drive) @(negedge clk);
        n = 0;
        while (pin_drive) begin
            n++;
            @(negedge clk);
        end
    endtask

    // count released cycles until rst_done or a new drive
    task automatic low_window(output int n, output bit done);
        n = 0;
        done = 1'b0;
        forever begin
            if (rst_done) begin
                done = 1'b1;
                break;
            end
            if (pin_drive) break;
            n++;
            @(negedge clk);
        end
    endtask

    task automatic after_done(input string req);
        @(negedge clk);
        check(!rst_done && !sys_rst && !pins_safe && !pin_drive, req,
              "idle after done pulse", {rst_done, sys_rst, pins_safe, pin_drive}, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_power_on();
        int n, bad;
        bit done;
        repeat (3) @(negedge clk);
        check(pin_drive && pins_safe && !sys_rst && !rst_done, "R1", "state in power-on reset",
              {pin_drive, pins_safe, sys_rst, rst_done}, 4'b1100);
        por_n = 1'b1;
        bad = 0;
        repeat (30) begin
            @(negedge clk);
            if (!pin_drive || sys_rst) bad++;
        end
        check(bad == 0, "R2", "drive held, master reset off before lock", bad, 0);
        pll_locked = 1'b1;
        @(negedge clk);
        bad = 0;
        n = 0;
        while (pin_drive) begin
            n++;
            if (sys_rst) bad++;
            @(negedge clk);
        end
        check(n == STR, "R2", "drive cycles after lock", n, STR);
        low_window(n, done);
        check(n == REL && done, "R3", "power-on release window", n, REL);
        check(bad == 0 && !sys_rst, "R2", "master reset during power-on", bad, 0);
        after_done("R3");
    endtask

    task automatic t_int_short();
        int n;
        bit done;
        int_req = 1'b1;
        @(negedge clk);
        int_req = 1'b0;
        check(pin_drive && sys_rst && pins_safe, "R5", "response one cycle after request",
              {pin_drive, sys_rst, pins_safe}, 3'b111);
        run_high(n);
        check(n == STR, "R5", "short request drive length", n, STR);
        low_window(n, done);
        check(n == REL && done, "R3", "release window after internal", n, REL);
        check(!sys_rst, "R10", "master reset off with done pulse", sys_rst, 0);
        after_done("R10");
    endtask

    task automatic t_int_long();
        int n;
        bit done;
        int len = STR + 20;
        int_req = 1'b1;
        n = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (pin_drive) n++;
        end
        int_req = 1'b0;
        @(negedge clk);
        while (pin_drive) begin
            n++;
            @(negedge clk);
        end
        check(n == len, "R5", "long request drive length", n, len);
        low_window(n, done);
        check(n == REL && done, "R3", "release window after long request", n, REL);
        after_done("R3");
    endtask

    task automatic t_glitch();
        int bad = 0;
        ext_low = 1'b1;
        repeat (MNL - 1) @(negedge clk);
        ext_low = 1'b0;
        repeat (30) begin
            @(negedge clk);
            if (pin_drive || sys_rst || pins_safe) bad++;
        end
        check(bad == 0, "R6", "short low pulse ignored", bad, 0);
    endtask

    task automatic t_ext_idle();
        int n;
        bit done;
        ext_low = 1'b1;
        repeat (20) @(negedge clk);
        check(sys_rst && !pin_drive && pins_safe, "R7", "board holds pad",
              {sys_rst, pin_drive, pins_safe}, 3'b101);
        ext_low = 1'b0;
        run_high(n);
        check(n == STR, "R7", "stretch after external release", n, STR);
        low_window(n, done);
        check(n == REL && done, "R3", "release window after external", n, REL);
        after_done("R9");
    endtask

    task automatic t_ext_bus(input bit use_tmo);
        int n;
        bit done;
        bus_busy = 1'b1;
        ext_low = 1'b1;
        repeat (20) @(negedge clk);
        check(!sys_rst && !pins_safe, "R8", "deferred while bus busy",
              {sys_rst, pins_safe}, 0);
        if (use_tmo) bus_tmo = 1'b1;
        else         bus_busy = 1'b0;
        @(negedge clk);
        bus_tmo = 1'b0;
        check(sys_rst && pins_safe, "R8", use_tmo ? "acted on timeout" : "acted on bus idle",
              {sys_rst, pins_safe}, 3);
        bus_busy = 1'b0;
        ext_low = 1'b0;
        run_high(n);
        check(n == STR, "R7", "stretch after deferred reset", n, STR);
        low_window(n, done);
        check(done, "R3", "done after deferred reset", done, 1);
        after_done("R8");
    endtask

    task automatic t_retest();
        int n;
        bit done;
        int_req = 1'b1;
        @(negedge clk);
        int_req = 1'b0;
        ext_low = 1'b1;
        run_high(n);
        check(n == STR, "R4", "first drive", n, STR);
        low_window(n, done);
        check(n == REL && !done, "R4", "first window fails test", {n, done}, REL << 1);
        run_high(n);
        check(n == STR, "R4", "repeated drive", n, STR);
        ext_low = 1'b0;
        low_window(n, done);
        check(n == REL && done, "R4", "second window passes", n, REL);
        after_done("R4");
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        summary();
        $finish;
    end

    initial begin
        t_power_on();
        t_int_short();
        t_int_long();
        t_glitch();
        t_ext_idle();
        t_ext_bus(1'b0);
        t_ext_bus(1'b1);
        t_retest();
        summary();
        $finish;
    end
endmodule